// File: doc/BRIEF.md
# Per-Line Video CRC32 Inserter

This block sits in a parallel video pixel path (pixel word, data-enable, hsync, vsync). While data-enable is high it folds one 8-bit value per clock into a CRC32. A configurable bit mask picks which bits of the pixel word make up that value. When data-enable drops, the block waits a fixed number of clocks. It then overwrites three consecutive blanking words with the finished checksum (upper half first) and a status word. The status word carries a frame identifier and a per-frame line count.

Every other cycle passes through unchanged, with one clock of latency. A receiver can recompute the checksum over the same bits and compare, so the integrity check costs no active-video bandwidth.

Top module: `line_crc_inserter`

## Requirements
- R1: While rst_ni is low, pix_data_o, pix_de_o, pix_hs_o and pix_vs_o are all zero.
- R2: The CRC is MSB-first, with no reflection of input or output, polynomial 0x20044009 and no final XOR. For the line bytes "123456789" the inserted checksum is 0x4FD94EA8.
- R3: The CRC register reloads 0xFFFFFFFF on the first data-enable-high cycle of every line. It advances only on data-enable-high cycles, so two lines carrying the same data get the same checksum.
- R4: The CRC input value is built from the set bits of cfg_mask_i, scanned from bit 0 upward. The first set bit becomes value bit 0, the next becomes value bit 1, and so on. Only the first 8 set bits are used. If fewer than 8 bits are set, the remaining high bits of the value are zero.
- R5: Count the first data-enable-low input cycle after a line as k=0. Inputs at k=SLOT_OFS, SLOT_OFS+1 and SLOT_OFS+2 come out as CRC[31:16], CRC[15:0] and the status word. Each sits in bits [15:0] of pix_data_o, with all higher bits zero.
- R6: Status word bit 0 is the current frame identifier. Bits [15:1] hold the number of lines started in the current frame, including the line just ended.
- R7: The frame identifier is 0 after reset and toggles on every rising edge of pix_vs_i. A vsync rising edge also clears the line count.
- R8: On every cycle that is not a slot, pix_data_o, pix_de_o, pix_hs_o and pix_vs_o equal the inputs from one clock earlier.
- R9: If data-enable rises again before a slot position is reached, that slot and the later ones for that line are skipped. Active pixels are never overwritten.
- R10: Blanking before the first line after reset is passed through with no slot inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mask_i | input | PIX_W | Selects the pixel bits fed to the CRC |
| pix_data_i | input | PIX_W | Input pixel word |
| pix_de_i | input | 1 | Input data-enable |
| pix_hs_i | input | 1 | Input hsync |
| pix_vs_i | input | 1 | Input vsync |
| pix_data_o | output | PIX_W | Output pixel word with slots filled |
| pix_de_o | output | 1 | Delayed data-enable |
| pix_hs_o | output | 1 | Delayed hsync |
| pix_vs_o | output | 1 | Delayed vsync |

## Verification
The hardest case to reach is a line whose horizontal blanking is shorter than the slot offset. In that case the slot counter must give up before inserting anything, and the next line's pixels must stay untouched. The bench drives a line followed by a single blanking cycle and then an immediate second line. It checks that both blanking cycles and the second line's pixels pass through. It also checks that the second line's slots carry a checksum of its own data only. Mask handling is reached with a scattered mask, whose set bits sit at both ends of the word, and with a two-bit mask.

// File: rtl/line_crc_pkg.sv
package line_crc_pkg;
  localparam int          BYTE_W   = 8;
  localparam logic [31:0] CRC_POLY = 32'h2004_4009;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOUT = 32'h0000_0000;

  // MSB-first, non-reflected byte step
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [BYTE_W-1:0] b);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[31] ^ b[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/lc_byte_gather.sv
module lc_byte_gather
  import line_crc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic [PIX_W-1:0]  data_i,
  input  logic [PIX_W-1:0]  mask_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int IDX_W = $clog2(BYTE_W);

  always_comb begin
    logic [IDX_W:0] n;
    byte_o = '0;
    n      = '0;
    for (int i = 0; i < PIX_W; i++) begin
      if (mask_i[i] && (n < (IDX_W+1)'(BYTE_W))) begin
        byte_o[n[IDX_W-1:0]] = data_i[i];
        n = n + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lc_crc_engine.sv
module lc_crc_engine
  import line_crc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic [PIX_W-1:0] mask_i,
  input  logic             de_i,
  output logic [31:0]      crc_o
);
  logic [BYTE_W-1:0] byte_w;
  logic [31:0]       crc_q;
  logic              de_q;

  lc_byte_gather #(.PIX_W(PIX_W)) u_gather (
    .data_i (pix_data_i),
    .mask_i (mask_i),
    .byte_o (byte_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= CRC_INIT;
      de_q  <= 1'b0;
    end else begin
      de_q <= de_i;
      if (de_i) crc_q <= crc32_byte(de_q ? crc_q : CRC_INIT, byte_w);
    end
  end

  assign crc_o = crc_q ^ CRC_XOUT;

  AST_CRC_HOLD_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |=> $stable(crc_q)); // R3
  AST_GATHER_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> ($countones(byte_w) <= $countones(pix_data_i & mask_i))); // R4
endmodule

// File: rtl/lc_slot_ctrl.sv
module lc_slot_ctrl #(
  parameter int SLOT_OFS = 2,
  parameter int LCNT_W   = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_i,
  input  logic              vs_i,
  output logic              sel_hi_o,
  output logic              sel_lo_o,
  output logic              sel_st_o,
  output logic              frame_id_o,
  output logic [LCNT_W-1:0] line_cnt_o
);
  localparam int SAT   = SLOT_OFS + 3;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              de_q, vs_q, fid_q;
  logic [LCNT_W-1:0] lcnt_q;
  logic              vs_rise, de_rise;

  assign vs_rise = vs_i && !vs_q;
  assign de_rise = de_i && !de_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(SAT);
      de_q   <= 1'b0;
      vs_q   <= 1'b0;
      fid_q  <= 1'b0;
      lcnt_q <= '0;
    end else begin
      de_q <= de_i;
      vs_q <= vs_i;
      if (de_i) cnt_q <= '0;
      else if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
      if (vs_rise) fid_q <= ~fid_q;
      if (vs_rise) lcnt_q <= de_rise ? LCNT_W'(1) : '0;
      else if (de_rise) lcnt_q <= lcnt_q + 1'b1;
    end
  end

  assign sel_hi_o   = !de_i && (cnt_q == CNT_W'(SLOT_OFS));
  assign sel_lo_o   = !de_i && (cnt_q == CNT_W'(SLOT_OFS + 1));
  assign sel_st_o   = !de_i && (cnt_q == CNT_W'(SLOT_OFS + 2));
  assign frame_id_o = fid_q;
  assign line_cnt_o = lcnt_q;

  AST_SLOT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_hi_o, sel_lo_o, sel_st_o})); // R5
  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hi_o |=> (de_i || sel_lo_o)); // R5
  AST_FID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise |=> $stable(fid_q)); // R7
  AST_LCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise && !de_i) |=> (lcnt_q == '0)); // R7
endmodule

// File: rtl/line_crc_inserter.sv
module line_crc_inserter
  import line_crc_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int SLOT_OFS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] cfg_mask_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_de_i,
  input  logic             pix_hs_i,
  input  logic             pix_vs_i,
  output logic [PIX_W-1:0] pix_data_o,
  output logic             pix_de_o,
  output logic             pix_hs_o,
  output logic             pix_vs_o
);
  localparam int WORD_W = 16;
  localparam int LCNT_W = WORD_W - 1;

  logic [31:0]       crc_w;
  logic              sel_hi, sel_lo, sel_st, fid;
  logic [LCNT_W-1:0] lcnt;
  logic [WORD_W-1:0] status_w;
  logic              slot_q;

  lc_crc_engine #(.PIX_W(PIX_W)) u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_data_i (pix_data_i),
    .mask_i     (cfg_mask_i),
    .de_i       (pix_de_i),
    .crc_o      (crc_w)
  );

  lc_slot_ctrl #(.SLOT_OFS(SLOT_OFS), .LCNT_W(LCNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .de_i       (pix_de_i),
    .vs_i       (pix_vs_i),
    .sel_hi_o   (sel_hi),
    .sel_lo_o   (sel_lo),
    .sel_st_o   (sel_st),
    .frame_id_o (fid),
    .line_cnt_o (lcnt)
  );

  assign status_w = {lcnt, fid};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_data_o <= '0;
      pix_de_o   <= 1'b0;
      pix_hs_o   <= 1'b0;
      pix_vs_o   <= 1'b0;
      slot_q     <= 1'b0;
    end else begin
      pix_de_o <= pix_de_i;
      pix_hs_o <= pix_hs_i;
      pix_vs_o <= pix_vs_i;
      slot_q   <= sel_hi | sel_lo | sel_st;
      if (sel_hi)      pix_data_o <= PIX_W'(crc_w[31:16]);
      else if (sel_lo) pix_data_o <= PIX_W'(crc_w[15:0]);
      else if (sel_st) pix_data_o <= PIX_W'(status_w);
      else             pix_data_o <= pix_data_i;
    end
  end

  AST_NO_ACTIVE_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_de_o |-> !slot_q); // R9
  AST_SLOT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q |-> (pix_data_o >> WORD_W) == '0); // R5
  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pix_hs_o == $past(pix_hs_i)) && (pix_vs_o == $past(pix_vs_i))); // R8
endmodule

// File: tb/line_crc_inserter_test.sv
module line_crc_inserter_test;
  localparam int PW = 24;
  localparam int SO = 2;
  localparam logic [PW-1:0] BLANK = 24'hA5C3E7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] mask = 24'h0000FF;
  logic [PW-1:0] din = '0;
  logic          de = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [PW-1:0] dout;
  logic          de_o, hs_o, vs_o;

  int checks = 0, fails = 0;
  logic [PW-1:0] od;
  logic          ode, ohs, ovs;
  logic [PW-1:0] pix_buf [0:63];
  logic          exp_fid = 1'b0;
  int            exp_lines = 0;

  always #5 clk = ~clk;

  line_crc_inserter #(.PIX_W(PW), .SLOT_OFS(SO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mask_i(mask), .pix_data_i(din),
    .pix_de_i(de), .pix_hs_i(hs), .pix_vs_i(vs),
    .pix_data_o(dout), .pix_de_o(de_o), .pix_hs_o(hs_o), .pix_vs_o(vs_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one input cycle, return the output it produces
  task automatic step(input logic [PW-1:0] d, input logic e, input logic h, input logic v);
    @(negedge clk);
    din = d; de = e; hs = h; vs = v;
    @(posedge clk);
    #1;
    od = dout; ode = de_o; ohs = hs_o; ovs = vs_o;
  endtask

  function automatic logic [7:0] ref_gather(input logic [PW-1:0] d, input logic [PW-1:0] m);
    logic [7:0] r = '0;
    int k = 0;
    for (int i = 0; i < PW; i++)
      if (m[i]) begin
        if (k < 8) r[k] = d[i];
        k++;
      end
    return r;
  endfunction

  function automatic logic [31:0] ref_crc(input int n, input logic [PW-1:0] m);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int j = 0; j < n; j++) begin
      logic [7:0] b = ref_gather(pix_buf[j], m);
      for (int t = 7; t >= 0; t--) begin
        logic top = c[31];
        c = c << 1;
        if (top ^ b[t]) c = c ^ 32'h20044009;
      end
    end
    return c;
  endfunction

  // active line from pix_buf then blank_len blanking cycles; checks slots if reached
  task automatic run_line(input int n, input int blank_len, input string tag);
    logic [31:0] ec;
    logic [15:0] es;
    int bad = 0;
    exp_lines++;
    ec = ref_crc(n, mask);
    es = {exp_lines[14:0], exp_fid};
    for (int i = 0; i < n; i++) begin
      step(pix_buf[i], 1'b1, 1'b0, 1'b0);
      if (od !== pix_buf[i] || ode !== 1'b1) bad++;
    end
    chk(bad == 0, {"R8 active passthrough ", tag}, bad, 0);
    for (int k = 0; k < blank_len; k++) begin
      step(BLANK, 1'b0, k == 1, 1'b0);
      if (k == SO)
        chk(od === PW'(ec[31:16]), {"R5 crc hi ", tag}, od, ec[31:16]);
      else if (k == SO + 1)
        chk(od === PW'(ec[15:0]), {"R5 crc lo ", tag}, od, ec[15:0]);
      else if (k == SO + 2)
        chk(od === PW'(es), {"R6 status ", tag}, od, es);
      else
        chk(od === BLANK && ohs === (k == 1) && ode === 1'b0, {"R8 blank passthrough ", tag}, od, BLANK);
    end
  endtask

  task automatic vsync_pulse();
    for (int k = 0; k < 4; k++) begin
      step(BLANK, 1'b0, 1'b0, k < 2);
      chk(ovs === (k < 2) && od === BLANK, "R8 vsync passthrough", {31'd0, ovs}, {31'd0, k < 2});
    end
    exp_fid = ~exp_fid;
    exp_lines = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(dout === '0 && de_o === 1'b0 && hs_o === 1'b0 && vs_o === 1'b0, "R1 reset outputs", dout, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(BLANK, 1'b0, 1'b0, 1'b0);
      chk(od === BLANK, "R10 no slot before first line", od, BLANK);
    end
  endtask

  task automatic t_check_value();
    string s = "123456789";
    mask = 24'h0000FF;
    for (int i = 0; i < 9; i++) pix_buf[i] = {16'h7E00, s[i]};
    chk(ref_crc(9, mask) == 32'h4FD94EA8, "R2 reference model check value", ref_crc(9, mask), 32'h4FD94EA8);
    run_line(9, 8, "check value");
  endtask

  task automatic t_restart();
    run_line(9, 6, "repeat line R3");
  endtask

  task automatic t_mask_scattered();
    mask = 24'hF0000F;
    chk(ref_gather(24'h300005, mask) == 8'h35, "R4 gather order", ref_gather(24'h300005, mask), 8'h35);
    for (int i = 0; i < 20; i++) pix_buf[i] = PW'(32'h9E3779B9 * (i + 1));
    run_line(20, 6, "R4 scattered mask");
  endtask

  task automatic t_mask_sparse();
    mask = 24'h000300;
    for (int i = 0; i < 12; i++) pix_buf[i] = PW'(32'h0A5F3C11 * (i + 3));
    run_line(12, 6, "R4 two-bit mask");
    mask = 24'hFFFFFF;
    run_line(12, 6, "R4 full mask first eight");
  endtask

  task automatic t_vsync();
    mask = 24'h00FF00;
    vsync_pulse();
    for (int i = 0; i < 5; i++) pix_buf[i] = PW'(i * 24'h010203);
    run_line(5, 6, "R7 after first vsync");
    run_line(5, 6, "R7 second line of frame");
    vsync_pulse();
    run_line(5, 6, "R7 toggled back");
  endtask

  task automatic t_early();
    logic [31:0] ec;
    int bad = 0;
    mask = 24'h0000FF;
    for (int i = 0; i < 6; i++) pix_buf[i] = PW'(8'h40 + i);
    exp_lines++;
    for (int i = 0; i < 6; i++) step(pix_buf[i], 1'b1, 1'b0, 1'b0);
    step(BLANK, 1'b0, 1'b0, 1'b0);
    chk(od === BLANK, "R9 short blank k0 passthrough", od, BLANK);
    for (int i = 0; i < 4; i++) pix_buf[i] = PW'(8'hC0 + 3 * i);
    for (int i = 0; i < 4; i++) begin
      step(pix_buf[i], 1'b1, 1'b0, 1'b0);
      if (od !== pix_buf[i]) bad++;
    end
    chk(bad == 0, "R9 next line pixels untouched", bad, 0);
    exp_lines++;
    ec = ref_crc(4, mask);
    for (int k = 0; k < 6; k++) begin
      step(BLANK, 1'b0, 1'b0, 1'b0);
      if (k == SO) chk(od === PW'(ec[31:16]), "R3 second short line crc hi", od, ec[31:16]);
      if (k == SO + 1) chk(od === PW'(ec[15:0]), "R3 second short line crc lo", od, ec[15:0]);
      if (k == SO + 2) chk(od === PW'({exp_lines[14:0], exp_fid}), "R6 status after short line", od, {exp_lines[14:0], exp_fid});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_check_value();
    t_restart();
    t_mask_scattered();
    t_mask_sparse();
    t_vsync();
    t_early();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule